// File: doc/BRIEF.md
# Aliased Floating-Point and SIMD Register File

This block holds thirty-two 256-bit storage rows. Each row can be reached through three overlapping views of different widths. The scalar view covers the low 64 bits of a row. The 128-bit SIMD view covers the low 128 bits. The 256-bit SIMD view covers the whole row. The three views are windows onto the same flip-flops and not separate registers. A write through a narrow view therefore changes what a wider read of the same index returns. The aliasing works the same way at every index.

The block has two read ports and one write port. Each port carries an index and a 2-bit view code. A read returns the selected slice, zero-extended to 256 bits, and is combinational from the port's index and view. A write changes only the bits its view covers, at the rising clock edge on which the write enable is high.

Top module: `alias_vrf`

## Requirements
- R1: After synchronous reset (rst high at a rising edge), every bit of every row reads as zero through the 256-bit view.
- R2: View code 2'b00 (scalar, 64 bits) returns bits [63:0] of the indexed row, with bits [255:64] of the read data zero.
- R3: View code 2'b01 (128-bit SIMD) returns bits [127:0] of the indexed row, with bits [255:128] of the read data zero.
- R4: View code 2'b10 (256-bit SIMD) returns all 256 bits of the indexed row.
- R5: A write through view 2'b00 or 2'b01 replaces only bits [63:0] or [127:0] of the row. The row's upper bits keep their earlier value, and a following wide read shows old upper bits above new low bits.
- R6: View code 2'b11 is reserved. A write with it changes no row, and a read with it returns all zeros.
- R7: A read of the index being written in the same cycle returns the contents from before the write. The new value appears from the next cycle on.
- R8: With wr_en low, no row changes, whatever the other write inputs carry.
- R9: The aliasing holds at every index 0 to 31. A write to one index leaves every other row unchanged.
- R10: The two read ports select their index and view independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears all rows |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Row index of the write |
| wr_view | input | 2 | View code of the write |
| wr_data | input | 256 | Write data; only the bits the view covers are used |
| rda_idx | input | 5 | Row index of read port A |
| rda_view | input | 2 | View code of read port A |
| rda_data | output | 256 | Read port A data, zero-extended slice |
| rdb_idx | input | 5 | Row index of read port B |
| rdb_view | input | 2 | View code of read port B |
| rdb_data | output | 256 | Read port B data, zero-extended slice |

## Verification
The hardest situation to reach is a row whose layers were written through different views at different times. Its bits [255:128], [127:64] and [63:0] must each carry a distinct, recognisable value, so that a wrong merge mask shows up in a single wide read. The stimulus builds such rows on purpose at every index. It first fills a row through the 256-bit view, then overwrites it through the 128-bit view, then through the scalar view. Each layer uses a pattern that depends on the index. The row is then read back wide on one port while the other port reads a neighbouring index. Writes with the reserved view code and with the enable low, plus reads of the index being written in that same cycle, are mixed into a long random run. A behavioural model is checked against both ports on every clock.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    localparam int DEF_ROWS  = 32;
    localparam int DEF_ROW_W = 256;
    localparam int DEF_FP_W  = 64;
    localparam int DEF_SX_W  = 128;

    // Width view through which a row is accessed
    typedef enum logic [1:0] {
        VIEW_FP   = 2'b00,
        VIEW_SX   = 2'b01,
        VIEW_WX   = 2'b10,
        VIEW_NONE = 2'b11
    } view_e;

    // Is storage bit 'lane' reachable through view 'v'?
    function automatic logic lane_in_view(view_e v, int lane, int fp_w, int sx_w);
        case (v)
            VIEW_FP: return lane < fp_w;
            VIEW_SX: return lane < sx_w;
            VIEW_WX: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/vrf_view_mask.sv
module vrf_view_mask
    import vrf_pkg::*;
#(
    parameter int ROW_W = DEF_ROW_W,
    parameter int FP_W  = DEF_FP_W,
    parameter int SX_W  = DEF_SX_W
) (
    input  view_e              view_i,
    output logic [ROW_W-1:0]   mask_o
);

    always_comb begin
        for (int b = 0; b < ROW_W; b++) begin
            mask_o[b] = lane_in_view(view_i, b, FP_W, SX_W);
        end
    end

endmodule

// File: rtl/vrf_read_port.sv
module vrf_read_port
    import vrf_pkg::*;
#(
    parameter int ROWS  = DEF_ROWS,
    parameter int ROW_W = DEF_ROW_W,
    parameter int FP_W  = DEF_FP_W,
    parameter int SX_W  = DEF_SX_W,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic [ROWS-1:0][ROW_W-1:0] rows_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  view_e                      view_i,
    output logic [ROW_W-1:0]           data_o
);

    logic [ROW_W-1:0] sel_mask;

    vrf_view_mask #(
        .ROW_W (ROW_W),
        .FP_W  (FP_W),
        .SX_W  (SX_W)
    ) mask_i (
        .view_i (view_i),
        .mask_o (sel_mask)
    );

    // Slice selection with zero extension above the view width
    assign data_o = rows_i[idx_i] & sel_mask;

endmodule

// File: rtl/vrf_row_store.sv
module vrf_row_store
    import vrf_pkg::*;
#(
    parameter int ROWS  = DEF_ROWS,
    parameter int ROW_W = DEF_ROW_W,
    parameter int FP_W  = DEF_FP_W,
    parameter int SX_W  = DEF_SX_W,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en_i,
    input  logic [IDX_W-1:0]           wr_idx_i,
    input  view_e                      wr_view_i,
    input  logic [ROW_W-1:0]           wr_data_i,
    output logic [ROWS-1:0][ROW_W-1:0] rows_o
);

    logic [ROW_W-1:0] wr_mask;

    vrf_view_mask #(
        .ROW_W (ROW_W),
        .FP_W  (FP_W),
        .SX_W  (SX_W)
    ) wmask_i (
        .view_i (wr_view_i),
        .mask_o (wr_mask)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [ROW_W-1:0] row_q;
        logic             hit;

        assign hit = wr_en_i && (wr_idx_i == IDX_W'(r));

        // Merge: bits outside the view keep their value
        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else if (hit) begin
                row_q <= (row_q & ~wr_mask) | (wr_data_i & wr_mask);
            end
        end

        assign rows_o[r] = row_q;
    end

endmodule

// File: rtl/alias_vrf.sv
module alias_vrf
    import vrf_pkg::*;
#(
    parameter int ROWS  = DEF_ROWS,
    parameter int ROW_W = DEF_ROW_W,
    parameter int FP_W  = DEF_FP_W,
    parameter int SX_W  = DEF_SX_W,
    localparam int IDX_W = $clog2(ROWS),
    localparam int NRD   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_view,
    input  logic [ROW_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  rda_idx,
    input  logic [1:0]        rda_view,
    output logic [ROW_W-1:0]  rda_data,
    input  logic [IDX_W-1:0]  rdb_idx,
    input  logic [1:0]        rdb_view,
    output logic [ROW_W-1:0]  rdb_data
);

    logic [ROWS-1:0][ROW_W-1:0] rows;
    logic [NRD-1:0][IDX_W-1:0]  rd_idx;
    logic [NRD-1:0][1:0]        rd_view;
    logic [NRD-1:0][ROW_W-1:0]  rd_data;

    vrf_row_store #(
        .ROWS  (ROWS),
        .ROW_W (ROW_W),
        .FP_W  (FP_W),
        .SX_W  (SX_W)
    ) store_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_view_i (view_e'(wr_view)),
        .wr_data_i (wr_data),
        .rows_o    (rows)
    );

    assign rd_idx[0]  = rda_idx;
    assign rd_view[0] = rda_view;
    assign rd_idx[1]  = rdb_idx;
    assign rd_view[1] = rdb_view;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        vrf_read_port #(
            .ROWS  (ROWS),
            .ROW_W (ROW_W),
            .FP_W  (FP_W),
            .SX_W  (SX_W)
        ) port_i (
            .rows_i (rows),
            .idx_i  (rd_idx[p]),
            .view_i (view_e'(rd_view[p])),
            .data_o (rd_data[p])
        );
    end

    assign rda_data = rd_data[0];
    assign rdb_data = rd_data[1];

    // Assertions
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rows == '0)); // R1

    AST_FP_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (rda_view == VIEW_FP) |-> (rda_data[ROW_W-1:FP_W] == '0)); // R2

    AST_SX_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (rdb_view == VIEW_SX) |-> (rdb_data[ROW_W-1:SX_W] == '0)); // R3

    AST_FP_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == VIEW_FP) |=>
        (rows[$past(wr_idx)][ROW_W-1:FP_W] == $past(rows[wr_idx][ROW_W-1:FP_W]))); // R5

    AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == VIEW_NONE) |=> $stable(rows)); // R6

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rda_view == VIEW_NONE) |-> (rda_data == '0)); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rows)); // R8

endmodule

// File: tb/alias_vrf_tb_top.sv
module alias_vrf_tb_top;

    localparam int ROWS  = 32;
    localparam int ROW_W = 256;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_idx = '0;
    logic [1:0]        wr_view = '0;
    logic [ROW_W-1:0]  wr_data = '0;
    logic [4:0]        rda_idx = '0;
    logic [1:0]        rda_view = '0;
    logic [ROW_W-1:0]  rda_data;
    logic [4:0]        rdb_idx = '0;
    logic [1:0]        rdb_view = '0;
    logic [ROW_W-1:0]  rdb_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [ROW_W-1:0] model [ROWS];

    always #10 clk = ~clk;

    alias_vrf dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_view  (wr_view),
        .wr_data  (wr_data),
        .rda_idx  (rda_idx),
        .rda_view (rda_view),
        .rda_data (rda_data),
        .rdb_idx  (rdb_idx),
        .rdb_view (rdb_view),
        .rdb_data (rdb_data)
    );

    function automatic logic [ROW_W-1:0] expect_rd(int idx, logic [1:0] v);
        logic [ROW_W-1:0] r;
        r = model[idx];
        case (v)
            2'b00:   return {192'b0, r[63:0]};
            2'b01:   return {128'b0, r[127:0]};
            2'b10:   return r;
            default: return '0;
        endcase
    endfunction

    function automatic string view_tag(logic [1:0] v);
        case (v)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic compare(string port, string tag, logic [ROW_W-1:0] got,
                           logic [ROW_W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s port %s: got %h expected %h", tag, port, got, exp);
        end
    endtask

    // One cycle: drive, check reads before the edge, update model after it
    task automatic cycle(logic en, int widx, logic [1:0] wv, logic [ROW_W-1:0] wd,
                         int aidx, logic [1:0] av, int bidx, logic [1:0] bv,
                         string tag);
        @(negedge clk);
        wr_en = en; wr_idx = 5'(widx); wr_view = wv; wr_data = wd;
        rda_idx = 5'(aidx); rda_view = av; rdb_idx = 5'(bidx); rdb_view = bv;
        #1;
        compare("A", (tag == "") ? view_tag(av) : tag, rda_data, expect_rd(aidx, av));
        compare("B", (tag == "") ? view_tag(bv) : tag, rdb_data, expect_rd(bidx, bv));
        @(posedge clk);
        if (en && !rst) begin
            case (wv)
                2'b00: model[widx][63:0]  = wd[63:0];
                2'b01: model[widx][127:0] = wd[127:0];
                2'b10: model[widx]        = wd;
                default: ;
            endcase
        end
    endtask

    function automatic logic [ROW_W-1:0] rnd256();
        logic [ROW_W-1:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        for (int i = 0; i < ROWS; i++) model[i] = '0;
        // Scribble before reset so that reset has something to clear
        rst = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd3; wr_view = 2'b10; wr_data = '1;
        @(negedge clk);
        wr_en = 1'b0; rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: all rows read zero after reset
        for (int i = 0; i < ROWS; i++)
            cycle(1'b0, 0, 2'b10, '0, i, 2'b10, (i + 16) % ROWS, 2'b10, "R1");

        // R5: layered writes, then wide read shows old upper bits
        cycle(1'b1, 5, 2'b10, {8{32'hAAAA_5555}}, 0, 2'b10, 0, 2'b10, "R5");
        cycle(1'b1, 5, 2'b01, {8{32'h1234_5678}}, 5, 2'b10, 5, 2'b01, "R5");
        cycle(1'b1, 5, 2'b00, {8{32'hDEAD_BEEF}}, 5, 2'b10, 5, 2'b01, "R5");
        cycle(1'b0, 0, 2'b00, '0, 5, 2'b10, 5, 2'b00, "R5");

        // R7: same-index read during write returns old contents
        cycle(1'b1, 7, 2'b10, {8{32'hCAFE_F00D}}, 7, 2'b10, 7, 2'b00, "R7");
        cycle(1'b1, 7, 2'b00, '0, 7, 2'b10, 7, 2'b01, "R7");
        cycle(1'b0, 0, 2'b00, '0, 7, 2'b10, 7, 2'b00, "R7");

        // R8: enable low, data offered, no change
        cycle(1'b0, 5, 2'b10, '1, 5, 2'b10, 7, 2'b10, "R8");
        cycle(1'b0, 0, 2'b00, '0, 5, 2'b10, 7, 2'b10, "R8");

        // R6: reserved view write and read
        cycle(1'b1, 5, 2'b11, '1, 5, 2'b11, 5, 2'b10, "R6");
        cycle(1'b0, 0, 2'b00, '0, 5, 2'b10, 5, 2'b11, "R6");

        // R9 / R10: layered rows at every index, ports on different rows
        for (int i = 0; i < ROWS; i++) begin
            cycle(1'b1, i, 2'b10, {8{8'(i), 24'h0F0F0F}}, i, 2'b10, (i + 1) % ROWS, 2'b10, "R9");
            cycle(1'b1, i, 2'b01, {8{8'(i), 24'h330033}}, i, 2'b01, (i + 31) % ROWS, 2'b10, "R9");
            cycle(1'b1, i, 2'b00, {8{8'(i), 24'hABCDEF}}, i, 2'b00, i, 2'b10, "R10");
        end
        for (int i = 0; i < ROWS; i++)
            cycle(1'b0, 0, 2'b00, '0, i, 2'b10, ROWS - 1 - i, 2'b01, "R9");

        // Random run, checked against the model on every cycle
        for (int n = 0; n < 3000; n++) begin
            int wi;
            wi = $urandom_range(0, 7);
            cycle(1'($urandom_range(0, 3) != 0), wi, 2'($urandom), rnd256(),
                  ($urandom_range(0, 1) != 0) ? wi : $urandom_range(0, 7), 2'($urandom),
                  $urandom_range(0, ROWS - 1), 2'($urandom), "");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule